// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is the device side of a small serial EEPROM that sits on an SPI bus in mode 0. The bus pins are sampled with the system clock. Data is captured on rising SCK edges, and the reply bit is advanced on falling SCK edges. Each time chip select is pulled low, a new frame begins, and the first byte of the frame selects the command.

The commands are:
- Set or clear a write-enable latch.
- Read or update a status byte.
- Read one array byte at a 16-bit address.
- Write one array byte at a 16-bit address.

The storage is an internal register array of 2^ADDR_W bytes, and it powers up erased.

Every modifying command is held until chip select rises. At that point the frame is checked for completeness, for the write-enable latch and for block protection. If the frame passes, it is applied, and a busy interval of WRITE_CYCLES clocks begins. During this interval the in-progress flag reads as set. The master polls that flag through the status read, which is the only command served while the device is busy.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00 (bit 0 in-progress, bit 1 write-enable latch, bits 3:2 protect field, bits 7:4 zero), every array byte reads 0xFF, and MISO is high.
- R2: A frame of exactly one byte 0x06 sets the write-enable latch at the chip-select rise. A frame of exactly one byte 0x04 clears it.
- R3: After opcode 0x05, the status byte is returned MSB first in every following byte slot, and this command is served even while busy.
- R4: A WRITE frame is exactly four bytes: 0x02, address high, address low, data. It stores the data at the chip-select rise. The high address byte is ignored, and the low ADDR_W bits of the low byte index the array.
- R5: For opcode 0x03 followed by the two address bytes, the fourth slot returns the addressed byte whatever MOSI carries. All other slots of the frame return 0xFF.
- R6: WRITE and status-update frames leave array and status unchanged while the write-enable latch is 0.
- R7: An accepted write sets the in-progress flag for WRITE_CYCLES clocks. When the flag ends, the in-progress flag and the write-enable latch both clear.
- R8: While in-progress is 1, every command except the status read is ignored. A READ returns 0xFF in the data slot.
- R9: A status-update frame is exactly two bytes: 0x01, then a value. If accepted, it copies value bits 3:2 into the protect field and starts a busy interval.
- R10: Protect field 01 guards the top quarter of the array, 10 the top half and 11 all of it. A WRITE to a guarded address is dropped, with no busy interval, and the latch keeps its value.
- R11: A modifying frame that ends at the chip-select rise with missing or extra bits is discarded, and array and status stay unchanged.
- R12: MISO reads high whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select, frames a command |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, high when deselected |

## Verification
The bound checker watches the following on every clock:
- The protect field never moves while chip select stays low.
- The write-enable latch only rises and a busy interval only starts while chip select is high.
- A busy interval only starts with the latch set.
- The latch is clear once the busy flag drops.

The remaining behaviours can only be shown by the directed frames in the bench. These are the data values returned in specific byte slots, commands that are dropped for partial or oversized frames or for guarded addresses, and commands ignored during the busy interval.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {
    OUT_ONES   = 2'd0,
    OUT_STATUS = 2'd1,
    OUT_MEM    = 2'd2
  } outSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    clear;     // deselected: reset reply shifter
    logic    shiftIn;   // rising SCK: capture MOSI bit
    logic    loadOut;   // byte boundary on falling SCK
    logic    shiftOut;  // other falling SCK
    outSel_e outSel;
    logic    capAddr;   // low address byte complete
    logic    capData;   // data byte complete
    logic    commit;    // store data into the array
  } strobe_t;

endpackage

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiSck,
  input  logic              spiCsN,
  input  logic [7:0]        rxByte,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output logic [7:0]        status
);

  localparam int BW = $clog2(WRITE_CYCLES + 1);

  logic          sckQ, sckPrev, csQ, csPrev;
  logic [2:0]    bitCnt, byteIdx;
  logic [7:0]    opcode;
  logic [1:0]    pendBp, bp;
  logic          wel;
  logic [BW-1:0] busyCnt;
  logic          wip;
  logic          rise, fall, csRise, byteEnd, boundary, wholeByte;
  logic          protHit, wrenGo, wrdiGo, bpGo, writeGo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckQ    <= 1'b0;
      sckPrev <= 1'b0;
      csQ     <= 1'b1;
      csPrev  <= 1'b1;
    end else begin
      sckQ    <= spiSck;
      sckPrev <= sckQ;
      csQ     <= spiCsN;
      csPrev  <= csQ;
    end
  end

  assign rise      = !csQ && sckQ && !sckPrev;
  assign fall      = !csQ && !sckQ && sckPrev;
  assign csRise    = csQ && !csPrev;
  assign byteEnd   = rise && (bitCnt == 3'd7);
  assign boundary  = fall && (bitCnt == 3'd0) && (byteIdx != 3'd0);
  assign wholeByte = (bitCnt == 3'd0);
  assign wip       = (busyCnt != '0);

  always_comb begin
    unique case (bp)
      2'b00:   protHit = 1'b0;
      2'b01:   protHit = addr[ADDR_W-1] && addr[ADDR_W-2];
      2'b10:   protHit = addr[ADDR_W-1];
      default: protHit = 1'b1;
    endcase
  end

  // every frame is judged when chip select rises
  assign wrenGo  = csRise && !wip && wholeByte && byteIdx == 3'd1 && opcode == OP_WREN;
  assign wrdiGo  = csRise && !wip && wholeByte && byteIdx == 3'd1 && opcode == OP_WRDI;
  assign bpGo    = csRise && !wip && wel && wholeByte && byteIdx == 3'd2 && opcode == OP_WRSR;
  assign writeGo = csRise && !wip && wel && wholeByte && byteIdx == 3'd4 &&
                   opcode == OP_WRITE && !protHit;

  always_comb begin
    strb          = '0;
    strb.clear    = csQ;
    strb.shiftIn  = rise;
    strb.loadOut  = boundary;
    strb.shiftOut = fall && !boundary;
    if (opcode == OP_RDSR)
      strb.outSel = OUT_STATUS;
    else if (opcode == OP_READ && byteIdx == 3'd3 && !wip)
      strb.outSel = OUT_MEM;
    else
      strb.outSel = OUT_ONES;
    strb.capAddr  = byteEnd && byteIdx == 3'd2;
    strb.capData  = byteEnd && byteIdx == 3'd3;
    strb.commit   = writeGo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt  <= '0;
      byteIdx <= '0;
      opcode  <= '0;
      pendBp  <= '0;
    end else begin
      if (csQ) begin
        bitCnt  <= '0;
        byteIdx <= '0;
      end else if (rise) begin
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7 && byteIdx != 3'd7) byteIdx <= byteIdx + 3'd1;
      end
      if (byteEnd && byteIdx == 3'd0) opcode <= rxByte;
      if (byteEnd && byteIdx == 3'd1) pendBp <= rxByte[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel     <= 1'b0;
      bp      <= 2'b00;
      busyCnt <= '0;
    end else begin
      if (wrenGo)                      wel <= 1'b1;
      else if (wrdiGo)                 wel <= 1'b0;
      else if (busyCnt == BW'(1))      wel <= 1'b0;
      if (bpGo) bp <= pendBp;
      if (writeGo || bpGo)             busyCnt <= BW'(WRITE_CYCLES);
      else if (wip)                    busyCnt <= busyCnt - BW'(1);
    end
  end

  assign status = {4'b0000, bp, wel, wip};

endmodule

// File: rtl/spi_eeprom_datapath.sv
module spi_eeprom_datapath
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiMosi,
  input  strobe_t           strb,
  input  logic [7:0]        status,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] addr,
  output logic              outMsb
);

  localparam int DEPTH = 1 << ADDR_W;

  logic              mosiQ;
  logic [7:0]        shiftInReg, outReg, dataReg, memRd;
  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        mem [DEPTH];

  assign rxByte = {shiftInReg[6:0], mosiQ};
  assign addr   = addrReg;
  assign memRd  = mem[addrReg];
  assign outMsb = outReg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mosiQ      <= 1'b0;
      shiftInReg <= '0;
      addrReg    <= '0;
      dataReg    <= '0;
      outReg     <= 8'hFF;
    end else begin
      mosiQ <= spiMosi;
      if (strb.shiftIn) shiftInReg <= rxByte;
      if (strb.capAddr) addrReg <= rxByte[ADDR_W-1:0];
      if (strb.capData) dataReg <= rxByte;
      if (strb.clear) outReg <= 8'hFF;
      else if (strb.loadOut) begin
        unique case (strb.outSel)
          OUT_STATUS: outReg <= status;
          OUT_MEM:    outReg <= memRd;
          default:    outReg <= 8'hFF;
        endcase
      end else if (strb.shiftOut) outReg <= {outReg[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (strb.commit) begin
      mem[addrReg] <= dataReg;
    end
  end

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);

  strobe_t           strb;
  logic [7:0]        status, rxByte;
  logic [ADDR_W-1:0] addr;
  logic              outMsb;

  spi_eeprom_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .spiSck(spi_sck), .spiCsN(spi_cs_n),
    .rxByte(rxByte), .addr(addr), .strb(strb), .status(status)
  );

  spi_eeprom_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .spiMosi(spi_mosi), .strb(strb),
    .status(status), .rxByte(rxByte), .addr(addr), .outMsb(outMsb)
  );

  assign spi_miso = spi_cs_n ? 1'b1 : outMsb;

endmodule

// File: rtl/spi_eeprom_checker.sv
module spi_eeprom_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       csN,
  input logic [7:0] status
);

  assert_bp_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && $past(!csN)) |-> $stable(status[3:2]));

  assert_wel_rise_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> csN);

  assert_busy_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> status[1]);

  assert_busy_start_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> csN);

  assert_wel_clear_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

endmodule

bind spi_eeprom_slave spi_eeprom_checker chk (
  .clk(clk), .rst_n(rst_n), .csN(spi_cs_n), .status(status)
);

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  spi_eeprom_slave #(.ADDR_W(8), .WRITE_CYCLES(1000)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nBits; i--) begin
      spi_mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      repeat (4) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic csOn();
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csOff();
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    csOn(); xferBits(op, 8, r); csOff();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    csOn(); xferBits(8'h05, 8, r); xferBits(8'h00, 8, st); csOff();
  endtask

  task automatic readByte(input logic [7:0] hi, input logic [7:0] lo,
                          output logic [7:0] slot2, output logic [7:0] d);
    logic [7:0] r;
    csOn();
    xferBits(8'h03, 8, r); xferBits(hi, 8, r); xferBits(lo, 8, slot2);
    xferBits(8'h5A, 8, d);
    csOff();
  endtask

  task automatic writeByte(input logic [7:0] lo, input logic [7:0] d);
    logic [7:0] r;
    csOn();
    xferBits(8'h02, 8, r); xferBits(8'h00, 8, r); xferBits(lo, 8, r); xferBits(d, 8, r);
    csOff();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    csOn(); xferBits(8'h01, 8, r); xferBits(v, 8, r); csOff();
  endtask

  task automatic waitIdle();
    logic [7:0] st;
    for (int n = 0; n < 40; n++) begin
      rdsr(st);
      if (!st[0]) return;
    end
    check("R7 busy never ended", st, 8'h00);
  endtask

  task automatic testReset();
    logic [7:0] st, s2, d;
    check("R12 miso idle", {7'b0, spi_miso}, 8'h01);
    rdsr(st);
    check("R1 status after reset", st, 8'h00);
    readByte(8'h00, 8'h10, s2, d);
    check("R1 erased byte", d, 8'hFF);
    check("R5 address slot ones", s2, 8'hFF);
  endtask

  task automatic testLatch();
    logic [7:0] st;
    cmd1(8'h06); rdsr(st);
    check("R2 WREN sets latch", st, 8'h02);
    cmd1(8'h04); rdsr(st);
    check("R2 WRDI clears latch", st, 8'h00);
  endtask

  task automatic testNoWel();
    logic [7:0] st, s2, d;
    writeByte(8'h10, 8'hA5);
    wrsr(8'h0C);
    rdsr(st);
    check("R6 status unchanged", st, 8'h00);
    readByte(8'h00, 8'h10, s2, d);
    check("R6 array unchanged", d, 8'hFF);
  endtask

  task automatic testWrite();
    logic [7:0] st, s2, d, r, st2;
    cmd1(8'h06);
    writeByte(8'h10, 8'hA5);
    csOn(); xferBits(8'h05, 8, r); xferBits(8'h00, 8, st); xferBits(8'h00, 8, st2); csOff();
    check("R7 busy after write", st, 8'h03);
    check("R3 status repeats", st2, 8'h03);
    readByte(8'h00, 8'h10, s2, d);
    check("R8 read while busy", d, 8'hFF);
    cmd1(8'h06);
    waitIdle();
    rdsr(st);
    check("R7 idle clears latch", st, 8'h00);
    check("R8 WREN while busy ignored", st, 8'h00);
    readByte(8'h00, 8'h10, s2, d);
    check("R4 stored byte", d, 8'hA5);
    readByte(8'h01, 8'h10, s2, d);
    check("R4 high byte ignored", d, 8'hA5);
  endtask

  task automatic testAbort();
    logic [7:0] st, s2, d, r;
    cmd1(8'h06);
    csOn();
    xferBits(8'h02, 8, r); xferBits(8'h00, 8, r); xferBits(8'h20, 8, r); xferBits(8'h77, 4, r);
    csOff();
    rdsr(st);
    check("R11 short frame status", st, 8'h02);
    csOn();
    xferBits(8'h02, 8, r); xferBits(8'h00, 8, r); xferBits(8'h20, 8, r);
    xferBits(8'h77, 8, r); xferBits(8'h11, 8, r);
    csOff();
    rdsr(st);
    check("R11 long frame status", st, 8'h02);
    readByte(8'h00, 8'h20, s2, d);
    check("R11 array untouched", d, 8'hFF);
    cmd1(8'h04);
  endtask

  task automatic testProtect();
    logic [7:0] st, s2, d;
    cmd1(8'h06); wrsr(8'h04);
    rdsr(st);
    check("R9 WRSR starts busy", st, 8'h07);
    waitIdle(); rdsr(st);
    check("R9 protect field set", st, 8'h04);
    cmd1(8'h06); writeByte(8'hC0, 8'h55);
    rdsr(st);
    check("R10 guarded write no busy", st, 8'h06);
    readByte(8'h00, 8'hC0, s2, d);
    check("R10 guarded byte kept", d, 8'hFF);
    writeByte(8'hBF, 8'h3C); waitIdle();
    readByte(8'h00, 8'hBF, s2, d);
    check("R10 open byte written", d, 8'h3C);
    check("R12 miso high after frame", {7'b0, spi_miso}, 8'h01);
    cmd1(8'h06); wrsr(8'h08); waitIdle();
    cmd1(8'h06); writeByte(8'h80, 8'h99);
    readByte(8'h00, 8'h80, s2, d);
    check("R10 half guarded", d, 8'hFF);
    wrsr(8'h0C); waitIdle(); rdsr(st);
    check("R10 all guarded field", st, 8'h0C);
    cmd1(8'h06); writeByte(8'h00, 8'h42);
    readByte(8'h00, 8'h00, s2, d);
    check("R10 all guarded byte", d, 8'hFF);
    wrsr(8'h00); waitIdle(); rdsr(st);
    check("R9 protect cleared", st, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testLatch();
    testNoWel();
    testWrite();
    testAbort();
    testProtect();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule